// File: doc/BRIEF.md
# Memory copy access controller

This block moves a fixed-size block of data words from one region of external memory to another. Two independent engines share a small on-chip dual-port buffer. The fetch engine issues a single burst read request on a simplified memory read port and stores each returned word in the buffer. The store engine later streams the buffer contents, starting at buffer index zero, out through a simplified memory write port. The write port obeys back-pressure from a single ready input.

Each engine is started by the rising edge of its own level-sensitive go input. A go input held high therefore starts exactly one transaction. The source address, the destination address and the block length in words are module parameters. The request address and length outputs carry their values only while the matching valid signal is high, and read zero at all other times. The two engines do not coordinate with each other: the integrating logic starts the store engine only after the fetch engine has filled the buffer.

Top module: `mem_copy_ctrl`

## Requirements
- R1: Only a rising edge of `fetch_go` or `store_go` starts a transaction. Holding either input high after its transaction completes starts no further request or data beat, even while the ready inputs are high.
- R2: After a fetch start, `fetch_req_valid` stays low for as long as `fetch_req_ready` is low. The request is raised in the cycle after the first clock edge at which `fetch_req_ready` is sampled high.
- R3: The fetch request is a single-cycle pulse of `fetch_req_valid`, with `fetch_req_addr` = SRC_BASE and `fetch_req_len` = LEN. When valid is low, both fields read zero.
- R4: After the request, each cycle with `fetch_rsp_valid` high stores `fetch_rsp_data` at the next buffer index, starting from 0. After LEN words the fetch engine returns to waiting for a start. Response words presented at any other time are discarded and do not alter the buffer.
- R5: After a store start, `store_valid` stays low until `store_ready` has been sampled high. While `store_valid` is high, `store_addr` = DST_BASE and `store_len` = LEN. Otherwise they read zero.
- R6: A beat is transferred at each clock edge where `store_valid` and `store_ready` are both high. The beats carry buffer indices 0 to LEN-1 in order, exactly LEN beats per transaction.
- R7: If `store_ready` is low at an edge where `store_valid` is high, `store_valid` is low in the next cycle. When ready returns, streaming resumes with the same word that was not accepted.
- R8: A rising edge on either go input while its engine is busy is ignored. The running transaction continues unchanged.
- R9: Under reset (synchronous, active low), all valid outputs and all address, length and data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_go | input | 1 | Fetch start level; its rising edge starts one burst read |
| store_go | input | 1 | Store start level; its rising edge starts one burst write |
| fetch_req_addr | output | AW | Byte address of the read burst, valid with `fetch_req_valid` |
| fetch_req_len | output | LW | Word count of the read burst, valid with `fetch_req_valid` |
| fetch_req_valid | output | 1 | Single-cycle read request strobe |
| fetch_req_ready | input | 1 | Read request may be issued |
| fetch_rsp_data | input | DW | Returned read word |
| fetch_rsp_valid | input | 1 | `fetch_rsp_data` is valid this cycle |
| store_addr | output | AW | Destination byte address, valid with `store_valid` |
| store_len | output | LW | Destination word count, valid with `store_valid` |
| store_valid | output | 1 | `store_data` carries a beat this cycle |
| store_data | output | DW | Write data beat |
| store_ready | input | 1 | Sink accepts a beat at this edge |

## Verification
The bench builds the block with a six-word block, so the buffer index is not a power of two and the prefetch clamp at the final index is exercised on every store pass. The source and destination addresses are distinct and non-trivial. With LEN at six, each pass finishes within a few dozen cycles. This leaves room for several full copy passes with random response gaps and random write back-pressure, one pass with no gaps and constant ready, and passes that pulse a go input in mid-transfer. Stray response words are injected after the fetch engine has finished, and each go input is held high long after its transaction ends.

// File: rtl/mcc_pkg.sv
// Package: state encodings shared by the memory copy controller engines.
// Assumes: both engines use a two-bit state register.
package mcc_pkg;

    // Fetch (read side) engine states
    typedef enum logic [1:0] {
        RD_PARK      = 2'd0,
        RD_WAIT_RDY  = 2'd1,
        RD_ISSUE     = 2'd2,
        RD_COLLECT   = 2'd3
    } rd_state_e;

    // Store (write side) engine states
    typedef enum logic [1:0] {
        WR_PARK      = 2'd0,
        WR_WAIT_RDY  = 2'd1,
        WR_STREAM    = 2'd2,
        WR_HOLD      = 2'd3
    } wr_state_e;

endpackage

// File: rtl/mcc_rise_detect.sv
// Module: mcc_rise_detect
// Turns a level start input into a one-cycle pulse on its rising edge.
// Assumes: level is synchronous to clk; the previous level resets to 0.
module mcc_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic pulse
);

    logic level_q;

    // Remember last cycle's level
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign pulse = level & ~level_q;

    // R1: a held level never yields two pulses in a row
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/mcc_copy_buf.sv
// Module: mcc_copy_buf
// Simple dual-port buffer: one synchronous write port, one read port
// with a registered output (one-cycle read latency).
// Assumes: both addresses stay below DEPTH; contents are not reset.
module mcc_copy_buf #(
    parameter int unsigned DW    = 32,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned IW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam logic [IW:0] DEPTH_W = (IW+1)'(DEPTH);

    logic [DW-1:0] mem [DEPTH];

    // Write port
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else        rdata <= mem[raddr];
    end

    // R4: fill index stays inside the buffer
    a_r4_waddr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> ({1'b0, waddr} < DEPTH_W));

    // R6: drain index stays inside the buffer
    a_r6_raddr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, raddr} < DEPTH_W);

endmodule

// File: rtl/mcc_rd_ctrl.sv
// Module: mcc_rd_ctrl
// Fetch engine: on a start pulse it waits for request-ready, issues one
// burst read request, and stores LEN returned words into the buffer at
// indices 0..LEN-1.
// Assumes: the responder returns exactly LEN words after the request.
module mcc_rd_ctrl
    import mcc_pkg::*;
#(
    parameter int unsigned AW  = 32,
    parameter int unsigned DW  = 32,
    parameter int unsigned LEN = 16,
    parameter int unsigned IW  = 4,
    parameter int unsigned LW  = 5,
    parameter logic [AW-1:0] SRC_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_pulse,
    input  logic          req_ready,
    input  logic [DW-1:0] rsp_data,
    input  logic          rsp_valid,
    output logic [AW-1:0] req_addr,
    output logic [LW-1:0] req_len,
    output logic          req_valid,
    output logic          buf_we,
    output logic [IW-1:0] buf_waddr,
    output logic [DW-1:0] buf_wdata
);

    localparam logic [IW-1:0] LAST   = IW'(LEN - 1);
    localparam logic [LW-1:0] LEN_LW = LW'(LEN);

    rd_state_e     state;
    logic [IW-1:0] cnt;

    // State sequencing and fill-index counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RD_PARK;
            cnt   <= '0;
        end else begin
            unique case (state)
                RD_PARK: begin
                    cnt <= '0;
                    if (go_pulse) state <= RD_WAIT_RDY;
                end
                RD_WAIT_RDY: begin
                    if (req_ready) state <= RD_ISSUE;
                end
                RD_ISSUE: begin
                    cnt   <= '0;
                    state <= RD_COLLECT;
                end
                RD_COLLECT: begin
                    if (rsp_valid) begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            state <= RD_PARK;
                        end else begin
                            cnt <= cnt + IW'(1);
                        end
                    end
                end
                default: state <= RD_PARK;
            endcase
        end
    end

    // Request fields are driven only while the request is valid
    always_comb begin
        req_valid = (state == RD_ISSUE);
        req_addr  = req_valid ? SRC_BASE : '0;
        req_len   = req_valid ? LEN_LW   : '0;
    end

    // Buffer write side is quiet outside the collect state
    always_comb begin
        buf_we    = (state == RD_COLLECT) && rsp_valid;
        buf_waddr = buf_we ? cnt      : '0;
        buf_wdata = buf_we ? rsp_data : '0;
    end

    // R3: request strobe lasts a single cycle
    a_r3_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    // R2: request only follows a sampled ready
    a_r2_req_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_valid) |-> $past(req_ready));

    // R4: fill index never passes the last slot
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R8: a start pulse during collection does not disturb it
    a_r8_rd_busy_ignores_go: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RD_COLLECT && go_pulse && !rsp_valid) |=> (state == RD_COLLECT));

endmodule

// File: rtl/mcc_wr_ctrl.sv
// Module: mcc_wr_ctrl
// Store engine: on a start pulse it waits for write-ready, then streams
// buffer words 0..LEN-1, one per accepted cycle, pausing in a hold state
// whenever ready drops.
// Assumes: the buffer read port has one cycle of latency; the engine
// prefetches the next index so that a beat is available every cycle.
module mcc_wr_ctrl
    import mcc_pkg::*;
#(
    parameter int unsigned AW  = 32,
    parameter int unsigned DW  = 32,
    parameter int unsigned LEN = 16,
    parameter int unsigned IW  = 4,
    parameter int unsigned LW  = 5,
    parameter logic [AW-1:0] DST_BASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_pulse,
    input  logic          wr_ready,
    input  logic [DW-1:0] buf_rdata,
    output logic [IW-1:0] buf_raddr,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [LW-1:0] wr_len,
    output logic [DW-1:0] wr_data
);

    localparam logic [IW-1:0] LAST   = IW'(LEN - 1);
    localparam logic [LW-1:0] LEN_LW = LW'(LEN);

    wr_state_e     state;
    logic [IW-1:0] cnt;
    logic          take;

    assign take = (state == WR_STREAM) && wr_ready;

    // State sequencing and beat counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= WR_PARK;
            cnt   <= '0;
        end else begin
            unique case (state)
                WR_PARK: begin
                    cnt <= '0;
                    if (go_pulse) state <= WR_WAIT_RDY;
                end
                WR_WAIT_RDY: begin
                    if (wr_ready) state <= WR_STREAM;
                end
                WR_STREAM: begin
                    if (wr_ready) begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            state <= WR_PARK;
                        end else begin
                            cnt <= cnt + IW'(1);
                        end
                    end else begin
                        state <= WR_HOLD;
                    end
                end
                WR_HOLD: begin
                    if (wr_ready) state <= WR_STREAM;
                end
                default: state <= WR_PARK;
            endcase
        end
    end

    // Prefetch address: step ahead on an accepted beat, clamp at the end
    always_comb begin
        if (take && (cnt != LAST)) buf_raddr = cnt + IW'(1);
        else                       buf_raddr = cnt;
    end

    // Beat outputs are zero whenever no beat is offered
    always_comb begin
        wr_valid = (state == WR_STREAM);
        wr_data  = wr_valid ? buf_rdata : '0;
        wr_addr  = wr_valid ? DST_BASE  : '0;
        wr_len   = wr_valid ? LEN_LW    : '0;
    end

    // R7: an unaccepted beat is withdrawn in the next cycle
    a_r7_stop_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> !wr_valid);

    // R5: streaming only starts or resumes after ready was sampled
    a_r5_stream_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |-> $past(wr_ready));

    // R6: beat index never passes the last slot
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

    // R8: a start pulse during hold does not disturb the transaction
    a_r8_wr_busy_ignores_go: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WR_HOLD && go_pulse && !wr_ready) |=> (state == WR_HOLD));

endmodule

// File: rtl/mem_copy_ctrl.sv
// Module: mem_copy_ctrl (top)
// Copies LEN words from SRC_BASE to DST_BASE: the fetch engine fills a
// dual-port buffer from the read port, and the store engine drains it to
// the write port. Each engine is started by the rising edge of its go input.
// Assumes: store_go rises only after the fetch engine has filled the buffer;
// LEN >= 2 and SRC_BASE differs from DST_BASE.
module mem_copy_ctrl #(
    parameter int unsigned AW  = 32,
    parameter int unsigned DW  = 32,
    parameter int unsigned LEN = 16,
    parameter logic [AW-1:0] SRC_BASE = 32'h0000_1000,
    parameter logic [AW-1:0] DST_BASE = 32'h0004_0000,
    localparam int unsigned IW = (LEN > 1) ? $clog2(LEN) : 1,
    localparam int unsigned LW = $clog2(LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_go,
    input  logic          store_go,
    output logic [AW-1:0] fetch_req_addr,
    output logic [LW-1:0] fetch_req_len,
    output logic          fetch_req_valid,
    input  logic          fetch_req_ready,
    input  logic [DW-1:0] fetch_rsp_data,
    input  logic          fetch_rsp_valid,
    output logic [AW-1:0] store_addr,
    output logic [LW-1:0] store_len,
    output logic          store_valid,
    output logic [DW-1:0] store_data,
    input  logic          store_ready
);

    logic          fetch_pulse;
    logic          store_pulse;
    logic          buf_we;
    logic [IW-1:0] buf_waddr;
    logic [DW-1:0] buf_wdata;
    logic [IW-1:0] buf_raddr;
    logic [DW-1:0] buf_rdata;

    // Start edge detection, one per engine
    mcc_rise_detect u_fetch_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (fetch_go),
        .pulse (fetch_pulse)
    );

    mcc_rise_detect u_store_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (store_go),
        .pulse (store_pulse)
    );

    // Fetch engine
    mcc_rd_ctrl #(
        .AW(AW), .DW(DW), .LEN(LEN), .IW(IW), .LW(LW), .SRC_BASE(SRC_BASE)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_pulse  (fetch_pulse),
        .req_ready (fetch_req_ready),
        .rsp_data  (fetch_rsp_data),
        .rsp_valid (fetch_rsp_valid),
        .req_addr  (fetch_req_addr),
        .req_len   (fetch_req_len),
        .req_valid (fetch_req_valid),
        .buf_we    (buf_we),
        .buf_waddr (buf_waddr),
        .buf_wdata (buf_wdata)
    );

    // Shared word buffer
    mcc_copy_buf #(
        .DW(DW), .DEPTH(LEN), .IW(IW)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (buf_raddr),
        .rdata (buf_rdata)
    );

    // Store engine
    mcc_wr_ctrl #(
        .AW(AW), .DW(DW), .LEN(LEN), .IW(IW), .LW(LW), .DST_BASE(DST_BASE)
    ) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_pulse  (store_pulse),
        .wr_ready  (store_ready),
        .buf_rdata (buf_rdata),
        .buf_raddr (buf_raddr),
        .wr_valid  (store_valid),
        .wr_addr   (store_addr),
        .wr_len    (store_len),
        .wr_data   (store_data)
    );

endmodule

// File: tb/mem_copy_ctrl_test.sv
// Bench for mem_copy_ctrl: random response gaps and back-pressure from a
// fixed seed, plus directed no-gap and mid-transfer start-pulse passes.
module mem_copy_ctrl_test;

    localparam int unsigned T_AW  = 32;
    localparam int unsigned T_DW  = 32;
    localparam int unsigned T_LEN = 6;
    localparam int unsigned T_LW  = $clog2(T_LEN + 1);
    localparam logic [31:0] T_SRC = 32'h0000_1400;
    localparam logic [31:0] T_DST = 32'h0002_0080;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            fetch_go = 1'b0;
    logic            store_go = 1'b0;
    logic [T_AW-1:0] fetch_req_addr;
    logic [T_LW-1:0] fetch_req_len;
    logic            fetch_req_valid;
    logic            fetch_req_ready = 1'b0;
    logic [T_DW-1:0] fetch_rsp_data = '0;
    logic            fetch_rsp_valid = 1'b0;
    logic [T_AW-1:0] store_addr;
    logic [T_LW-1:0] store_len;
    logic            store_valid;
    logic [T_DW-1:0] store_data;
    logic            store_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;
    logic [T_DW-1:0] exp_w [T_LEN];

    always #5 clk = ~clk;

    mem_copy_ctrl #(
        .AW(T_AW), .DW(T_DW), .LEN(T_LEN), .SRC_BASE(T_SRC), .DST_BASE(T_DST)
    ) uut (
        .clk(clk), .rst_n(rst_n), .fetch_go(fetch_go), .store_go(store_go),
        .fetch_req_addr(fetch_req_addr), .fetch_req_len(fetch_req_len),
        .fetch_req_valid(fetch_req_valid), .fetch_req_ready(fetch_req_ready),
        .fetch_rsp_data(fetch_rsp_data), .fetch_rsp_valid(fetch_rsp_valid),
        .store_addr(store_addr), .store_len(store_len), .store_valid(store_valid),
        .store_data(store_data), .store_ready(store_ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    // Expected length field as the requirements define it
    function automatic logic [T_LW-1:0] exp_len();
        return T_LW'(T_LEN);
    endfunction

    // Stray word pattern that must never reach the write port
    function automatic logic [T_DW-1:0] junk_word(input int k);
        return 32'hDEAD_0000 ^ T_DW'(k * 32'h0101);
    endfunction

    // Fetch pass. mode 0: random; 1: no gaps; 2: random plus go pulse mid-collect
    task automatic run_read(input int mode);
        int waits;
        waits = (mode == 1) ? 0 : int'($urandom_range(4, 1));
        fetch_go = 1'b1;
        fetch_req_ready = 1'b0;
        fetch_rsp_valid = (mode == 2);
        fetch_rsp_data = junk_word(99);
        @(negedge clk);
        chk(fetch_req_valid == 1'b0, "R2", "no request before ready", 64'(fetch_req_valid), 0);
        for (int i = 0; i < waits; i++) begin
            @(negedge clk);
            chk(fetch_req_valid == 1'b0, "R2", "request while ready low", 64'(fetch_req_valid), 0);
        end
        fetch_req_ready = 1'b1;
        fetch_rsp_valid = 1'b0;
        @(negedge clk);
        chk(fetch_req_valid == 1'b1, "R2", "request after ready", 64'(fetch_req_valid), 1);
        chk(fetch_req_addr == T_SRC, "R3", "request addr", 64'(fetch_req_addr), 64'(T_SRC));
        chk(fetch_req_len == exp_len(), "R3", "request len", 64'(fetch_req_len), 64'(exp_len()));
        fetch_req_ready = 1'($urandom_range(1, 0));
        @(negedge clk);
        chk(fetch_req_valid == 1'b0, "R3", "request pulse width", 64'(fetch_req_valid), 0);
        chk(fetch_req_addr == '0, "R3", "addr idle zero", 64'(fetch_req_addr), 0);
        chk(fetch_req_len == '0, "R3", "len idle zero", 64'(fetch_req_len), 0);
        for (int k = 0; k < T_LEN; k++) begin
            int gap;
            gap = (mode == 1) ? 0 : int'($urandom_range(2, 0));
            fetch_rsp_valid = 1'b0;
            fetch_rsp_data = junk_word(k);
            for (int g = 0; g < gap; g++) @(negedge clk);
            if (mode == 2 && k == 2) begin
                fetch_go = 1'b0;
                @(negedge clk);
                fetch_go = 1'b1; // R8: rising edge while collecting
                @(negedge clk);
            end
            fetch_rsp_valid = 1'b1;
            fetch_rsp_data = exp_w[k];
            @(negedge clk);
        end
        // R1 and R4: go held high, ready high, stray words offered
        fetch_req_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            fetch_rsp_valid = 1'b1;
            fetch_rsp_data = junk_word(i + 20);
            @(negedge clk);
            chk(fetch_req_valid == 1'b0, "R1", "fetch restarted on held go", 64'(fetch_req_valid), 0);
        end
        fetch_rsp_valid = 1'b0;
        fetch_req_ready = 1'b0;
        fetch_go = 1'b0;
        @(negedge clk);
    endtask

    // Store pass. mode 0: random ready; 1: ready always high; 2: random plus go pulse
    task automatic run_write(input int mode);
        int beat;
        int cyc;
        bit pend;
        bit nr;
        beat = 0;
        cyc = 0;
        pend = 1'b0;
        store_go = 1'b1;
        store_ready = 1'b0;
        @(negedge clk);
        chk(store_valid == 1'b0, "R5", "beat before ready", 64'(store_valid), 0);
        while (beat < T_LEN && cyc < 400) begin
            if (pend)
                chk(store_valid == 1'b0, "R7", "valid after refused beat", 64'(store_valid), 0);
            if (store_valid) begin
                chk(store_addr == T_DST, "R5", "dest addr", 64'(store_addr), 64'(T_DST));
                chk(store_len == exp_len(), "R5", "dest len", 64'(store_len), 64'(exp_len()));
            end else begin
                chk(store_addr == '0 && store_len == '0 && store_data == '0, "R5",
                    "fields zero when idle", 64'(store_addr), 0);
            end
            nr = (mode == 1) ? 1'b1 : ($urandom_range(99, 0) < 55);
            if (mode == 2 && cyc == 4) store_go = 1'b0;
            if (mode == 2 && cyc == 5) store_go = 1'b1; // R8: edge while busy
            store_ready = nr;
            if (store_valid && nr) begin
                chk(store_data == exp_w[beat], "R6", $sformatf("beat %0d data", beat),
                    64'(store_data), 64'(exp_w[beat]));
                beat++;
            end else if (store_valid) begin
                chk(store_data == exp_w[beat], "R7", $sformatf("held beat %0d data", beat),
                    64'(store_data), 64'(exp_w[beat]));
            end
            pend = store_valid && !nr;
            @(negedge clk);
            cyc++;
        end
        chk(beat == T_LEN, "R6", "beat count", 64'(beat), 64'(T_LEN));
        store_ready = 1'b1;
        for (int i = 0; i < 6; i++) begin
            chk(store_valid == 1'b0, "R1", "extra beat on held go", 64'(store_valid), 0);
            @(negedge clk);
        end
        store_go = 1'b0;
        store_ready = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Main sequence
    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        chk(fetch_req_valid == 1'b0 && store_valid == 1'b0, "R9", "valids in reset",
            64'({fetch_req_valid, store_valid}), 0);
        chk(fetch_req_addr == '0 && fetch_req_len == '0, "R9", "read fields in reset",
            64'(fetch_req_addr), 0);
        chk(store_addr == '0 && store_len == '0 && store_data == '0, "R9",
            "write fields in reset", 64'(store_data), 0);
        rst_n = 1'b1;
        store_ready = 1'b1;
        fetch_req_ready = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(store_valid == 1'b0 && fetch_req_valid == 1'b0, "R1", "no start without edge",
                64'({fetch_req_valid, store_valid}), 0);
        end
        store_ready = 1'b0;
        fetch_req_ready = 1'b0;
        for (int p = 0; p < 5; p++) begin
            int mode;
            mode = (p == 1) ? 1 : ((p == 3) ? 2 : 0);
            for (int k = 0; k < T_LEN; k++) exp_w[k] = $urandom;
            if (p == 4) begin
                exp_w[0] = '0;
                exp_w[T_LEN-1] = '1;
            end
            run_read(mode);
            run_write(mode);
        end
        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule